// File: doc/BRIEF.md
# Two's-Complement Adder-Subtractor Unit

This block is a purely combinational arithmetic unit of parameterizable width (8 bits by default). A 2-bit operation code selects one of four functions: add, subtract, increment or decrement. All four share one ripple chain of full-adder cells. The functions differ only in how the second operand and the initial carry are conditioned before the chain. Subtraction feeds the bitwise complement of the second operand together with a carry seed of one. Increment and decrement replace the second operand with a constant: all zeros with a seed of one, or all ones with a seed of zero.

The unit reports the low WIDTH bits of the result, the carry leaving the top cell, and a signed overflow flag. The overflow flag is the exclusive-or of the carry entering the most significant cell and the carry leaving it. The unit has no clock and no state. A surrounding pipeline registers its inputs and outputs where timing calls for it.

Top module: `addsub_unit`

## Requirements
- R1: With op_sel = 2'b00 (add), result equals (opnd_a + opnd_b) mod 2^WIDTH and carry_out equals bit WIDTH of the unsigned sum.
- R2: With op_sel = 2'b01 (subtract), result equals (opnd_a - opnd_b) mod 2^WIDTH, and carry_out is 1 exactly when opnd_a >= opnd_b as unsigned numbers.
- R3: overflow is 1 exactly when the true signed result of the selected operation lies outside the two's-complement range of WIDTH bits. The four signed results are a+b, a-b, a+1 and a-1.
- R4: With op_sel = 2'b10 (increment), result equals (opnd_a + 1) mod 2^WIDTH, and carry_out is 1 exactly when opnd_a is all ones.
- R5: With op_sel = 2'b11 (decrement), result equals (opnd_a - 1) mod 2^WIDTH, and carry_out is 1 exactly when opnd_a is not zero.
- R6: In increment and decrement modes, opnd_b has no effect on result, carry_out or overflow.
- R7: All outputs settle within the same cycle as an input change, with no register between the inputs and the outputs.
- R8: With WIDTH = 4, every combination of operands and operation code produces outputs that meet R1 to R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 2 | Operation code: 00 add, 01 subtract, 10 increment, 11 decrement |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand (add and subtract only) |
| result | output | WIDTH | Sum or difference, low WIDTH bits |
| carry_out | output | 1 | Carry leaving the most significant cell |
| overflow | output | 1 | Signed two's-complement overflow |

## Verification
Every output is due in the same cycle as the stimulus, because no register lies on any path through the unit. The bench drives new operands just after a rising clock edge. It samples result, carry_out and overflow at the following falling edge, half a period later, when the ripple chain has settled. One directed check changes the inputs and samples after a single time unit, without any clock edge in between, to show that no stage is clocked.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_INC = 2'b10,
        OP_DEC = 2'b11
    } arith_op_e;

endpackage

// File: rtl/addsub_fa_cell.sv
module addsub_fa_cell (
    input  logic x_bit,
    input  logic y_bit,
    input  logic c_in,
    output logic s_bit,
    output logic c_out
);
    logic half_sum;

    always_comb begin
        half_sum = x_bit ^ y_bit;
        s_bit    = half_sum ^ c_in;
        c_out    = (x_bit & y_bit) | (c_in & half_sum);
    end
endmodule

// File: rtl/addsub_operand_sel.sv
module addsub_operand_sel
    import addsub_pkg::*;
#(
    parameter int W = 8
) (
    input  arith_op_e        op,
    input  logic [W-1:0]     b_raw,
    output logic [W-1:0]     b_eff,
    output logic             carry_seed
);
    // one select per bit: pass, complement, force low, force high
    for (genvar i = 0; i < W; i++) begin : g_bit_sel
        always_comb begin
            unique case (op)
                OP_ADD: b_eff[i] = b_raw[i];
                OP_SUB: b_eff[i] = ~b_raw[i];
                OP_INC: b_eff[i] = 1'b0;
                OP_DEC: b_eff[i] = 1'b1;
            endcase
        end
    end

    always_comb begin
        unique case (op)
            OP_ADD:  carry_seed = 1'b0;
            OP_SUB:  carry_seed = 1'b1;
            OP_INC:  carry_seed = 1'b1;
            OP_DEC:  carry_seed = 1'b0;
        endcase
    end
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
    parameter int W = 8
) (
    input  logic [W-1:0] x_vec,
    input  logic [W-1:0] y_vec,
    input  logic         c_seed,
    output logic [W-1:0] s_vec,
    output logic         c_into_msb,
    output logic         c_final
);
    localparam int MSB = W - 1;

    logic [W:0] chain;

    assign chain[0] = c_seed;

    for (genvar i = 0; i < W; i++) begin : g_stage
        addsub_fa_cell u_cell (
            .x_bit (x_vec[i]),
            .y_bit (y_vec[i]),
            .c_in  (chain[i]),
            .s_bit (s_vec[i]),
            .c_out (chain[i+1])
        );
    end

    assign c_into_msb = chain[MSB];
    assign c_final    = chain[W];
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags (
    input  logic c_into_msb,
    input  logic c_final,
    output logic carry_flag,
    output logic ovf_flag
);
    always_comb begin
        carry_flag = c_final;
        ovf_flag   = c_into_msb ^ c_final;
    end
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
    import addsub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [1:0]       op_sel,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             overflow
);
    arith_op_e        op_q;
    logic [WIDTH-1:0] b_cond;
    logic             seed;
    logic             c_msb_in;
    logic             c_top;

    assign op_q = arith_op_e'(op_sel);

    addsub_operand_sel #(.W(WIDTH)) u_opsel (
        .op         (op_q),
        .b_raw      (opnd_b),
        .b_eff      (b_cond),
        .carry_seed (seed)
    );

    addsub_ripple #(.W(WIDTH)) u_chain (
        .x_vec      (opnd_a),
        .y_vec      (b_cond),
        .c_seed     (seed),
        .s_vec      (result),
        .c_into_msb (c_msb_in),
        .c_final    (c_top)
    );

    addsub_flags u_flags (
        .c_into_msb (c_msb_in),
        .c_final    (c_top),
        .carry_flag (carry_out),
        .ovf_flag   (overflow)
    );
endmodule

// File: rtl/addsub_unit_chk.sv
module addsub_unit_chk #(
    parameter int W = 8
) (
    input logic [1:0]   op_sel,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [W-1:0] result,
    input logic         carry_out,
    input logic         overflow
);
    localparam int MSB = W - 1;

    logic [W:0] wide_add;
    logic [W:0] wide_inc;
    logic       sa, sb, sr;
    logic       known;

    always_comb begin
        wide_add = {1'b0, opnd_a} + {1'b0, opnd_b};
        wide_inc = {1'b0, opnd_a} + {{W{1'b0}}, 1'b1};
        sa       = opnd_a[MSB];
        sb       = opnd_b[MSB];
        sr       = result[MSB];
        known    = !$isunknown({op_sel, opnd_a, opnd_b});
    end

    always_comb begin
        if (known) begin
            if (op_sel == 2'b00)
                p_add_sum_r1: assert ({carry_out, result} == wide_add);
            if (op_sel == 2'b01)
                p_sub_diff_r2: assert (result == W'(opnd_a - opnd_b)
                                       && carry_out == (opnd_a >= opnd_b));
            if (op_sel == 2'b00)
                p_ovf_add_r3: assert (overflow == ((sa == sb) && (sr != sa)));
            if (op_sel == 2'b01)
                p_ovf_sub_r3: assert (overflow == ((sa != sb) && (sr != sa)));
            if (op_sel == 2'b10)
                p_inc_r4: assert ({carry_out, result} == wide_inc
                                  && overflow == (!sa && sr));
            if (op_sel == 2'b11)
                p_dec_r5: assert (result == W'(opnd_a - 1'b1)
                                  && carry_out == (opnd_a != '0)
                                  && overflow == (sa && !sr));
        end
    end
endmodule

bind addsub_unit addsub_unit_chk #(.W(WIDTH)) u_chk (
    .op_sel    (op_sel),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .result    (result),
    .carry_out (carry_out),
    .overflow  (overflow)
);

// File: tb/tb_addsub_unit.sv
module tb_addsub_unit;
    localparam int CLK_PERIOD = 10;
    localparam int W8 = 8;
    localparam int W4 = 4;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [1:0]    op8, op4;
    logic [W8-1:0] a8, b8, r8;
    logic [W4-1:0] a4, b4, r4;
    logic          co8, ov8, co4, ov4;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    addsub_unit #(.WIDTH(W8)) dut (
        .op_sel(op8), .opnd_a(a8), .opnd_b(b8),
        .result(r8), .carry_out(co8), .overflow(ov8)
    );

    addsub_unit #(.WIDTH(W4)) dut_w4 (
        .op_sel(op4), .opnd_a(a4), .opnd_b(b4),
        .result(r4), .carry_out(co4), .overflow(ov4)
    );

    function automatic int sext(int w, int v);
        return (v >= (1 << (w-1))) ? v - (1 << w) : v;
    endfunction

    // returns {ovf, carry, result}
    function automatic int model(int w, int a, int b, int op);
        int mask, bb, cin, full, sv, co, ov, lo, hi;
        mask = (1 << w) - 1;
        case (op)
            0:       begin bb = b;           cin = 0; sv = sext(w,a) + sext(w,b); end
            1:       begin bb = (~b) & mask; cin = 1; sv = sext(w,a) - sext(w,b); end
            2:       begin bb = 0;           cin = 1; sv = sext(w,a) + 1; end
            default: begin bb = mask;        cin = 0; sv = sext(w,a) - 1; end
        endcase
        full = a + bb + cin;
        co   = (full >> w) & 1;
        lo   = -(1 << (w-1));
        hi   = (1 << (w-1)) - 1;
        ov   = (sv < lo || sv > hi) ? 1 : 0;
        return (ov << (w+1)) | (co << w) | (full & mask);
    endfunction

    function automatic string req_of(int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic compare(string req, int w, int op, int a, int b,
                           int got_r, int got_c, int got_o);
        int e, er, ec, eo;
        e  = model(w, a, b, op);
        er = e & ((1 << w) - 1);
        ec = (e >> w) & 1;
        eo = (e >> (w+1)) & 1;
        n_checks++;
        if (got_r != er || got_c != ec) begin
            n_fail++;
            $display("FAIL %s w=%0d op=%0d a=%0h b=%0h: got r=%0h c=%0d exp r=%0h c=%0d",
                     req, w, op, a, b, got_r, got_c, er, ec);
        end
        n_checks++;
        if (got_o != eo) begin
            n_fail++;
            $display("FAIL R3 (%s) w=%0d op=%0d a=%0h b=%0h: got ovf=%0d exp ovf=%0d",
                     req, w, op, a, b, got_o, eo);
        end
    endtask

    task automatic apply8(string req, int op, int a, int b);
        @(posedge clk);
        op8 = op[1:0]; a8 = a[7:0]; b8 = b[7:0];
        @(negedge clk);
        compare(req, W8, op, a & 255, b & 255, int'(r8), int'(co8), int'(ov8));
    endtask

    task automatic t_idle();
        apply8("R1", 0, 0, 0);
    endtask

    task automatic t_corners8();
        apply8("R1", 0, 8'hFF, 8'h01);
        apply8("R1", 0, 8'h7F, 8'h01);
        apply8("R1", 0, 8'h80, 8'h80);
        apply8("R1", 0, 8'h3C, 8'h42);
        apply8("R2", 1, 8'h00, 8'h01);
        apply8("R2", 1, 8'h80, 8'h01);
        apply8("R2", 1, 8'h00, 8'h80);
        apply8("R2", 1, 8'h55, 8'h55);
        apply8("R4", 2, 8'hFF, 8'h00);
        apply8("R4", 2, 8'h7F, 8'h00);
        apply8("R5", 3, 8'h00, 8'h00);
        apply8("R5", 3, 8'h80, 8'h00);
        apply8("R5", 3, 8'h01, 8'h00);
    endtask

    // R6: B must not matter in increment and decrement
    task automatic t_ignore_b();
        int pats[4] = '{0, 255, 8'hA5, 8'h5A};
        for (int op = 2; op < 4; op++)
            for (int k = 0; k < 4; k++)
                apply8("R6", op, 8'h7F, pats[k]);
    endtask

    // R7: outputs follow inputs without any clock edge
    task automatic t_same_cycle();
        @(negedge clk);
        op8 = 2'b00; a8 = 8'h10; b8 = 8'h20;
        #1;
        compare("R7", W8, 0, 8'h10, 8'h20, int'(r8), int'(co8), int'(ov8));
        op8 = 2'b01;
        #1;
        compare("R7", W8, 1, 8'h10, 8'h20, int'(r8), int'(co8), int'(ov8));
    endtask

    task automatic t_random8();
        for (int n = 0; n < 2000; n++) begin
            int op, a, b;
            op = int'($urandom_range(3, 0));
            a  = int'($urandom_range(255, 0));
            b  = int'($urandom_range(255, 0));
            apply8(req_of(op), op, a, b);
        end
    endtask

    // R8: exhaustive at width 4
    task automatic t_exhaustive4();
        for (int op = 0; op < 4; op++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++) begin
                    @(posedge clk);
                    op4 = op[1:0]; a4 = a[3:0]; b4 = b[3:0];
                    @(negedge clk);
                    compare({"R8/", req_of(op)}, W4, op, a, b,
                            int'(r4), int'(co4), int'(ov4));
                end
    endtask

    initial begin
        op8 = '0; a8 = '0; b8 = '0;
        op4 = '0; a4 = '0; b4 = '0;
        void'($urandom(32'd1234));
        t_idle();
        t_corners8();
        t_ignore_b();
        t_same_cycle();
        t_random8();
        t_exhaustive4();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired: got hang exp completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule